// File: doc/BRIEF.md
# Signed Word Load Unit

This block executes the five 64-bit signed-word load encodings: PC-relative literal, post-index, pre-index, scaled unsigned offset and extended register offset. When idle, it takes one 32-bit instruction together with the PC of that instruction. It reads the base and index registers through two combinational register-file read ports and forms the effective address. It then issues a single 4-byte read on a valid/ready memory port and waits for the response.

The returned word is sign-extended to 64 bits and written to the destination register. For the two indexed forms, the updated base is written back in the same cycle through a second write port. The unit does not touch the condition flags and has no port for them. Any instruction word that matches none of the five forms raises a one-cycle illegal flag, and the unit then stays idle.

Top module: `sword_load_unit`

## Requirements
- R1: When bits[31:24] = 0x98, the instruction is the literal form. Its request address is `pc` plus the sign-extended value of bits[23:5] multiplied by 4. The destination is bits[4:0].
- R2: The post-index form is bits[31:21] = 10111000100 with bits[11:10] = 01. It reads from the unmodified base register (bits[9:5]). It writes back the base plus the sign-extended 9-bit value in bits[20:12].
- R3: The pre-index form has the same fixed bits as R2 except bits[11:10] = 11. Both the request address and the written-back base equal the base plus the sign-extended bits[20:12].
- R4: The unsigned-offset form is bits[31:22] = 1011100110. Its address is the base plus the zero-extended bits[21:10] times 4. It performs no base writeback.
- R5: The register-offset form is bits[31:21] = 10111000101 with bits[11:10] = 10. The index register number is in bits[20:16]. The index is extended according to bits[15:13]:
  - 010: zero-extend the low 32 bits.
  - 011: take all 64 bits.
  - 110: sign-extend the low 32 bits.
  - 111: take all 64 bits.
  When bit 12 = 1, the extended index is shifted left by 2. The result is added to the base.
- R6: The cycle after the memory response is accepted, `rd_we` pulses for one cycle. `rd_wdata` then equals the 32-bit response sign-extended to 64 bits, and `rd_waddr` equals the destination field.
- R7: The register number 31 has a different meaning in each field:
  - Destination field: it names the zero register, so no data write occurs.
  - Index field: it reads as zero.
  - Base field: it names the stack pointer. The read port returns the stack pointer at index 31, and a base writeback to index 31 updates it.
- R8: The cycle after an unrecognised word is accepted, `illegal` pulses for one cycle. Unrecognised words include a register-offset word whose bits[14] = 0 and the bits[11:10] = 00 or 10 variants of the indexed pattern. For such a word there is no memory request and no register write.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address hold unchanged. After the handshake, the request drops.
- R10: `busy` is high from the cycle after acceptance until the writeback cycle. While it is high, `instr_valid` is ignored. The base writeback pulses in the same cycle as the data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered (taken when not busy) |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| busy | output | 1 | Unit holds an instruction |
| illegal | output | 1 | One-cycle pulse for an unrecognised word |
| rf_raddr_n | output | 5 | Base register read index (31 = stack pointer) |
| rf_rdata_n | input | XLEN | Base register value |
| rf_raddr_m | output | 5 | Index register read index |
| rf_rdata_m | input | XLEN | Index register value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | XLEN | Byte address of the 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | WORD_W | Returned word |
| rd_we | output | 1 | Destination write strobe |
| rd_waddr | output | 5 | Destination register index |
| rd_wdata | output | XLEN | Sign-extended load data |
| base_we | output | 1 | Base writeback strobe |
| base_waddr | output | 5 | Base register index (31 = stack pointer) |
| base_wdata | output | XLEN | Updated base value |

## Verification
The request is due one cycle after acceptance. The illegal flag is due in the same cycle where a request would otherwise appear. Both writes are due one cycle after the response is accepted. The bench drives each input on a falling edge and samples exactly one falling edge later. It checks the address at the falling edge where it raises ready, and checks both writes at the falling edge after the response cycle. Ready and response delays are randomised, so the hold rule and the ignore-while-busy rule are exercised at varying distances from acceptance.

// File: rtl/slu_pkg.sv
package slu_pkg;
  localparam int RIDX_W = 5;
  localparam logic [RIDX_W-1:0] IDX_31 = 5'd31;

  typedef enum logic [2:0] {
    F_NONE, F_LIT, F_POST, F_PRE, F_UOFF, F_REG
  } form_e;

  typedef struct packed {
    form_e             form;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rm;
    logic [18:0]       imm19;
    logic [8:0]        imm9;
    logic [11:0]       imm12;
    logic [2:0]        opt;
    logic              sh;
  } dec_t;
endpackage

// File: rtl/slu_decode.sv
module slu_decode
  import slu_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec,
  output logic        bad
);
  logic m_lit, m_post, m_pre, m_uoff, m_reg;

  always_comb begin
    m_lit  = (instr[31:24] == 8'h98);
    m_post = (instr[31:21] == 11'b10111000100) && (instr[11:10] == 2'b01);
    m_pre  = (instr[31:21] == 11'b10111000100) && (instr[11:10] == 2'b11);
    m_uoff = (instr[31:22] == 10'b1011100110);
    m_reg  = (instr[31:21] == 11'b10111000101) && (instr[11:10] == 2'b10)
             && instr[14];

    dec.rt    = instr[4:0];
    dec.rn    = instr[9:5];
    dec.rm    = instr[20:16];
    dec.imm19 = instr[23:5];
    dec.imm9  = instr[20:12];
    dec.imm12 = instr[21:10];
    dec.opt   = instr[15:13];
    dec.sh    = instr[12];

    if (m_lit)       dec.form = F_LIT;
    else if (m_post) dec.form = F_POST;
    else if (m_pre)  dec.form = F_PRE;
    else if (m_uoff) dec.form = F_UOFF;
    else if (m_reg)  dec.form = F_REG;
    else             dec.form = F_NONE;

    bad = (dec.form == F_NONE);
  end
endmodule

// File: rtl/slu_agen.sv
module slu_agen
  import slu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  dec_t            dec,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] index,
  output logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] new_base,
  output logic            wb_en
);
  localparam int SCALE = 2;

  logic [XLEN-1:0] off9, off19, off12, ext_idx, scl_idx;

  always_comb begin
    off9  = {{(XLEN-9){dec.imm9[8]}}, dec.imm9};
    off19 = {{(XLEN-19-SCALE){dec.imm19[18]}}, dec.imm19, {SCALE{1'b0}}};
    off12 = {{(XLEN-12-SCALE){1'b0}}, dec.imm12, {SCALE{1'b0}}};

    case (dec.opt)
      3'b010:  ext_idx = {{(XLEN-WORD_W){1'b0}}, index[WORD_W-1:0]};
      3'b110:  ext_idx = {{(XLEN-WORD_W){index[WORD_W-1]}}, index[WORD_W-1:0]};
      default: ext_idx = index;
    endcase
    scl_idx = dec.sh ? (ext_idx << SCALE) : ext_idx;

    addr     = base;
    new_base = base + off9;
    wb_en    = 1'b0;
    case (dec.form)
      F_LIT:  addr = pc + off19;
      F_POST: wb_en = 1'b1;
      F_PRE: begin
        addr  = new_base;
        wb_en = 1'b1;
      end
      F_UOFF: addr = base + off12;
      F_REG:  addr = base + scl_idx;
      default: addr = base;
    endcase
  end
endmodule

// File: rtl/slu_sext.sv
module slu_sext #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  output logic [XLEN-1:0]   wide
);
  always_comb wide = {{(XLEN-WORD_W){word[WORD_W-1]}}, word};
endmodule

// File: rtl/sword_load_unit.sv
module sword_load_unit
  import slu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                instr_valid,
  input  logic [31:0]         instr,
  input  logic [XLEN-1:0]     pc,
  output logic                busy,
  output logic                illegal,
  output logic [RIDX_W-1:0]   rf_raddr_n,
  input  logic [XLEN-1:0]     rf_rdata_n,
  output logic [RIDX_W-1:0]   rf_raddr_m,
  input  logic [XLEN-1:0]     rf_rdata_m,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [XLEN-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [WORD_W-1:0]   mem_rsp_data,
  output logic                rd_we,
  output logic [RIDX_W-1:0]   rd_waddr,
  output logic [XLEN-1:0]     rd_wdata,
  output logic                base_we,
  output logic [RIDX_W-1:0]   base_waddr,
  output logic [XLEN-1:0]     base_wdata
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

  st_e             st;
  dec_t            dec;
  logic            dec_bad;
  logic [XLEN-1:0] index, ea, nb, load_val;
  logic            nb_en, accept;
  logic            wb_en_q;
  logic [XLEN-1:0] nb_q;

  slu_decode u_dec (.instr(instr), .dec(dec), .bad(dec_bad));

  assign rf_raddr_n = dec.rn;
  assign rf_raddr_m = dec.rm;
  assign index      = (dec.rm == IDX_31) ? '0 : rf_rdata_m;

  slu_agen #(.XLEN(XLEN), .WORD_W(WORD_W)) u_agen (
    .dec(dec), .pc(pc), .base(rf_rdata_n), .index(index),
    .addr(ea), .new_base(nb), .wb_en(nb_en)
  );

  slu_sext #(.XLEN(XLEN), .WORD_W(WORD_W)) u_sext (
    .word(mem_rsp_data), .wide(load_val)
  );

  assign accept = instr_valid && (st == S_IDLE);
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      illegal       <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rd_we         <= 1'b0;
      rd_waddr      <= '0;
      rd_wdata      <= '0;
      base_we       <= 1'b0;
      base_waddr    <= '0;
      base_wdata    <= '0;
      wb_en_q       <= 1'b0;
      nb_q          <= '0;
    end else begin
      illegal <= 1'b0;
      rd_we   <= 1'b0;
      base_we <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (dec_bad) begin
            illegal <= 1'b1;
          end else begin
            st            <= S_REQ;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= ea;
            rd_waddr      <= dec.rt;
            base_waddr    <= dec.rn;
            wb_en_q       <= nb_en;
            nb_q          <= nb;
          end
        end
        S_REQ: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          st            <= S_WAIT;
        end
        S_WAIT: if (mem_rsp_valid) begin
          rd_we      <= (rd_waddr != IDX_31);
          rd_wdata   <= load_val;
          base_we    <= wb_en_q;
          base_wdata <= nb_q;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9: request and address hold until taken
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8: illegal word causes no traffic
  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!mem_req_valid && !rd_we && !base_we && !busy));

  // R7: zero register is never written
  p_zr_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    rd_we |-> (rd_waddr != IDX_31));

  // R10: writes only follow an accepted response
  p_wb_after_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_we || base_we) |-> ($past(mem_rsp_valid) && $past(busy) && !busy));

  // R6: upper half of written data copies the word's sign bit
  p_sext_r6: assert property (@(posedge clk) disable iff (rst)
    rd_we |-> (rd_wdata[XLEN-1:WORD_W] == {(XLEN-WORD_W){rd_wdata[WORD_W-1]}}));
endmodule

// File: tb/tb_sword_load_unit.sv
module tb_sword_load_unit;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, instr_valid, busy, illegal;
  logic [31:0] instr;
  logic [63:0] pc;
  logic [4:0]  rf_raddr_n, rf_raddr_m, rd_waddr, base_waddr;
  logic [63:0] rf_rdata_n, rf_rdata_m, mem_req_addr, rd_wdata, base_wdata;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid, rd_we, base_we;
  logic [31:0] mem_rsp_data;

  logic [63:0] bregs [32];  // index 31 holds the stack pointer
  assign rf_rdata_n = bregs[rf_raddr_n];
  assign rf_rdata_m = bregs[rf_raddr_m];

  sword_load_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr), .pc(pc),
    .busy(busy), .illegal(illegal),
    .rf_raddr_n(rf_raddr_n), .rf_rdata_n(rf_rdata_n),
    .rf_raddr_m(rf_raddr_m), .rf_rdata_m(rf_rdata_m),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rd_we(rd_we), .rd_waddr(rd_waddr),
    .rd_wdata(rd_wdata), .base_we(base_we), .base_waddr(base_waddr),
    .base_wdata(base_wdata)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memw(input logic [63:0] a);
    return (a[31:0] * 32'h9E3779B1) ^ a[63:32] ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [63:0] sx32(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [31:0] enc(input int f, input logic [4:0] rt, input logic [4:0] rn,
                                      input logic [4:0] rm, input logic [18:0] i19,
                                      input logic [8:0] i9, input logic [11:0] i12,
                                      input logic [2:0] opt, input logic s);
    case (f)
      1: return {8'h98, i19, rt};
      2: return {11'b10111000100, i9, 2'b01, rn, rt};
      3: return {11'b10111000100, i9, 2'b11, rn, rt};
      4: return {10'b1011100110, i12, rn, rt};
      default: return {11'b10111000101, rm, opt, s, 2'b10, rn, rt};
    endcase
  endfunction

  function automatic string ftag(input int f);
    case (f)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic do_load(input int f, input logic [31:0] ins, input logic [63:0] pcv,
                         input bit use_fd, input logic [31:0] fd, input bit poke);
    logic [4:0]  rt, rn, rm;
    logic [63:0] base, idx, ea, nb, ext;
    logic        wbe;
    logic [31:0] d;
    bit          hs;
    int          dly;
    rt = ins[4:0]; rn = ins[9:5]; rm = ins[20:16];
    base = bregs[rn];
    wbe = 1'b0; nb = base;
    case (f)
      1: ea = pcv + {{43{ins[23]}}, ins[23:5], 2'b00};
      2: begin ea = base; nb = base + {{55{ins[20]}}, ins[20:12]}; wbe = 1'b1; end
      3: begin nb = base + {{55{ins[20]}}, ins[20:12]}; ea = nb; wbe = 1'b1; end
      4: ea = base + {50'd0, ins[21:10], 2'b00};
      default: begin
        idx = (rm == 5'd31) ? 64'd0 : bregs[rm];
        case (ins[15:13])
          3'b010: ext = {32'd0, idx[31:0]};
          3'b110: ext = sx32(idx[31:0]);
          default: ext = idx;
        endcase
        ea = base + (ins[12] ? (ext << 2) : ext);
      end
    endcase
    d = use_fd ? fd : memw(ea);

    @(negedge clk);
    instr = ins; pc = pcv; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R10 busy after accept", {63'd0, busy}, 64'd1);
    hs = 1'b0;
    while (!hs) begin
      mem_req_ready = (($urandom % 3) == 0);
      chk("R9 request held", {63'd0, mem_req_valid}, 64'd1);
      if (mem_req_ready) begin
        chk({ftag(f), " address"}, mem_req_addr, ea);
        hs = 1'b1;
      end
      @(negedge clk);
    end
    mem_req_ready = 1'b0;
    chk("R9 request dropped", {63'd0, mem_req_valid}, 64'd0);
    dly = poke ? 2 : int'($urandom % 3);
    for (int k = 0; k < dly; k++) begin
      if (poke) begin instr = 32'h0; instr_valid = 1'b1; end
      @(negedge clk);
      instr_valid = 1'b0;
      if (poke) chk("R10 ignored while busy", {62'd0, illegal, busy}, 64'd1);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = d;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R7 data write strobe", {63'd0, rd_we}, {63'd0, rt != 5'd31});
    if (rt != 5'd31) begin
      chk("R6 data index", {59'd0, rd_waddr}, {59'd0, rt});
      chk("R6 data value", rd_wdata, sx32(d));
    end
    chk("R10 base strobe", {63'd0, base_we}, {63'd0, wbe});
    if (wbe) begin
      chk({ftag(f), " base index"}, {59'd0, base_waddr}, {59'd0, rn});
      chk({ftag(f), " base value"}, base_wdata, nb);
    end
    chk("R10 idle after write", {63'd0, busy}, 64'd0);
    if (rt != 5'd31) bregs[rt] = sx32(d);
    if (wbe) bregs[rn] = nb;
  endtask

  task automatic do_illegal(input logic [31:0] ins);
    @(negedge clk);
    instr = ins; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R8 illegal pulse", {63'd0, illegal}, 64'd1);
    chk("R8 no request", {61'd0, mem_req_valid, rd_we, busy}, 64'd0);
    @(negedge clk);
    chk("R8 pulse ends", {62'd0, illegal, mem_req_valid}, 64'd0);
  endtask

  task automatic rnd_load();
    int f;
    logic [4:0] rt, rn;
    logic [2:0] opts [4];
    opts[0] = 3'b010; opts[1] = 3'b011; opts[2] = 3'b110; opts[3] = 3'b111;
    f = 1 + int'($urandom % 5);
    rt = 5'($urandom); rn = 5'($urandom);
    if ((f == 2 || f == 3) && rt == rn && rt != 5'd31) rt = rt ^ 5'd1;
    do_load(f, enc(f, rt, rn, 5'($urandom), 19'($urandom), 9'($urandom), 12'($urandom),
                   opts[$urandom % 4], 1'($urandom)),
            {$urandom, $urandom}, 1'b0, 32'd0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) bregs[i] = {$urandom, $urandom};
    rst = 1'b1; instr_valid = 1'b0; instr = '0; pc = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset state", {59'd0, busy, illegal, mem_req_valid, rd_we, base_we}, 64'd0);

    // R1: most negative and most positive literal offsets, sign boundary data
    do_load(1, enc(1, 5'd3, 0, 0, 19'h7FFFF, 0, 0, 0, 0), 64'h1000, 1'b1, 32'h8000_0000, 1'b0);
    do_load(1, enc(1, 5'd4, 0, 0, 19'h3FFFF, 0, 0, 0, 0), 64'h20, 1'b1, 32'h7FFF_FFFF, 1'b0);
    do_load(1, enc(1, 5'd5, 0, 0, 19'h40000, 0, 0, 0, 0), 64'h0, 1'b1, 32'hFFFF_FFFF, 1'b0);
    // R7: stack pointer as base with post and pre index, zero register as destination
    do_load(2, enc(2, 5'd6, 5'd31, 0, 0, 9'h1F0, 0, 0, 0), 64'h0, 1'b0, 0, 1'b0);
    do_load(3, enc(3, 5'd31, 5'd31, 0, 0, 9'h010, 0, 0, 0), 64'h0, 1'b0, 0, 1'b0);
    do_load(4, enc(4, 5'd31, 5'd7, 0, 0, 0, 12'hFFF, 0, 0), 64'h0, 1'b0, 0, 1'b0);
    // R5: each extend option, and index register 31 reading as zero
    bregs[9] = 64'h1234_5678_8000_0004;
    do_load(5, enc(5, 5'd1, 5'd2, 5'd9, 0, 0, 0, 3'b010, 1'b1), 64'h0, 1'b0, 0, 1'b0);
    do_load(5, enc(5, 5'd1, 5'd2, 5'd9, 0, 0, 0, 3'b110, 1'b1), 64'h0, 1'b0, 0, 1'b0);
    do_load(5, enc(5, 5'd1, 5'd2, 5'd9, 0, 0, 0, 3'b011, 1'b0), 64'h0, 1'b0, 0, 1'b0);
    do_load(5, enc(5, 5'd1, 5'd2, 5'd9, 0, 0, 0, 3'b111, 1'b1), 64'h0, 1'b0, 0, 1'b0);
    do_load(5, enc(5, 5'd8, 5'd2, 5'd31, 0, 0, 0, 3'b011, 1'b1), 64'h0, 1'b0, 0, 1'b0);
    // R10: an offered word during the wait is ignored
    do_load(4, enc(4, 5'd10, 5'd11, 0, 0, 0, 12'h005, 0, 0), 64'h0, 1'b0, 0, 1'b1);
    // R8: unrecognised words
    do_illegal(32'h0000_0000);
    do_illegal({11'b10111000100, 9'h004, 2'b00, 5'd1, 5'd2});
    do_illegal({11'b10111000100, 9'h004, 2'b10, 5'd1, 5'd2});
    do_illegal({11'b10111000101, 5'd3, 3'b001, 1'b0, 2'b10, 5'd1, 5'd2});
    do_illegal(32'hF9800000);
    do_load(1, enc(1, 5'd12, 0, 0, 19'h00001, 0, 0, 0, 0), 64'h40, 1'b0, 0, 1'b0);

    for (int i = 0; i < 400; i++) rnd_load();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule